// File: doc/BRIEF.md
# LUT Brightness Pattern Sequencer

This block plays a brightness pattern out of a small duty lookup table into one PWM channel. Software fills the table through a single write port. It then chooses a window of entries by a low and a high index and starts playback. The sequencer steps through the window at a fixed pace. It presents each entry on the duty output with no blending between neighbours, and it holds a busy flag while a pattern runs.

The pace comes from a millisecond tick input. Each entry is held for a 9-bit step duration, counted in ticks. The first entry of the pattern can be stretched by a low-pause multiplier and the last entry by a high-pause multiplier, and each stretch has its own enable bit.

Mode bits set the following:
- the direction of travel;
- whether playback repeats or makes one pass;
- whether it bounces between the two ends (ping-pong) instead of wrapping.

Equal low and high indices select the whole table. A stop input halts playback and leaves the output where it stands.

Top module: `lut_pattern_seq`

## Requirements
- R1: After reset, busy is 0, every table entry is 0 and the duty output is 0.
- R2: When lut_we is high at a clock edge, lut_wdata is stored at lut_waddr. The duty output always shows the entry at the current playback position, so a write to that entry appears on the duty output from the next cycle.
- R3: A start pulse loads the first entry of the pattern and raises busy on the next clock edge. The first entry is the low index, or the high index when cfg_reverse is 1.
- R4: Without ping-pong, playback runs from the first entry to the last entry of the pattern, one index per step, and then wraps to the first entry. The last entry is the high index, or the low index when cfg_reverse is 1.
- R5: An entry is held for cfg_step_dur ticks, with a value of 0 counted as 1. The position moves on the clock edge of the tick that ends the hold. A tick while busy is 0 has no effect.
- R6: When cfg_pause_lo_en is 1, the first entry is held for cfg_step_dur times cfg_lo_mult ticks. When cfg_pause_hi_en is 1, the last entry is held for cfg_step_dur times cfg_hi_mult ticks. A multiplier of 0 counts as 1. When a pause enable is 0, its multiplier has no effect.
- R7: With cfg_pingpong set, playback goes from the first entry to the last entry, then back to the first entry, and then forward again. An end entry is never played twice in a row.
- R8: With cfg_oneshot set, exactly one pass is made. In ping-pong mode that pass is out and back. When the final hold ends, busy falls and the duty output keeps the final entry.
- R9: When cfg_lo_idx equals cfg_hi_idx, the pattern covers the whole table: index 0 to the top index, or the reverse when cfg_reverse is 1.
- R10: A stop pulse clears busy on the next edge and takes priority over a simultaneous start. The duty output keeps its value and later ticks do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_we | input | 1 | Table write strobe |
| lut_waddr | input | IDX_W (4) | Table write address |
| lut_wdata | input | DUTY_W (9) | Table write data |
| cfg_lo_idx | input | IDX_W (4) | Low index of the pattern window |
| cfg_hi_idx | input | IDX_W (4) | High index of the pattern window; must not be below cfg_lo_idx unless equal-to-select-all |
| cfg_step_dur | input | DUR_W (9) | Ticks per step |
| cfg_lo_mult | input | MULT_W (8) | Low pause multiplier |
| cfg_hi_mult | input | MULT_W (8) | High pause multiplier |
| cfg_reverse | input | 1 | Play from the high index toward the low index |
| cfg_oneshot | input | 1 | Make a single pass instead of repeating |
| cfg_pingpong | input | 1 | Bounce between the ends instead of wrapping |
| cfg_pause_lo_en | input | 1 | Enable the first-entry stretch |
| cfg_pause_hi_en | input | 1 | Enable the last-entry stretch |
| start | input | 1 | Begin playback from the first entry |
| stop | input | 1 | Halt playback |
| ms_tick | input | 1 | Millisecond timebase pulse |
| duty_out | output | DUTY_W (9) | Duty value for the PWM channel |
| busy | output | 1 | Playback in progress |

## Verification
The hardest states to reach are the turnaround points of ping-pong playback and the end of a one-shot pass. At those points the direction register, the end-of-pattern test and the hold counter all act in the same cycle.

The bench reaches them with a pace of one tick per step, so that every tick is a step. It then walks a table of configurations: forward, reverse, ping-pong in both directions, one-shot with and without ping-pong, and the whole-table window. It checks the duty output and busy after every tick against an expected index sequence.

Directed tests then stretch the holds with both pauses and check the exact tick on which each stretched hold ends.

// File: rtl/lps_pkg.sv
package lps_pkg;

    // Playback direction relative to the pattern order.
    typedef enum logic {
        DIR_OUT  = 1'b0,   // toward the last entry
        DIR_BACK = 1'b1    // toward the first entry (ping-pong return)
    } dir_e;

    // Mode bits of the sequencer.
    typedef struct packed {
        logic reverse;
        logic oneshot;
        logic pingpong;
        logic pause_lo;
        logic pause_hi;
    } mode_t;

    // What happens when a hold expires.
    typedef enum logic [2:0] {
        ACT_STEP_OUT,
        ACT_STEP_BACK,
        ACT_WRAP,
        ACT_TURN,
        ACT_FINISH
    } act_e;

endpackage

// File: rtl/lps_lut.sv
module lps_lut #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int DUTY_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DUTY_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DUTY_W-1:0] rdata
);
    logic [DUTY_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/lps_window.sv
module lps_window #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] hi_idx,
    input  logic             reverse,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] last_idx
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] low_eff, high_eff;

    always_comb begin
        if (lo_idx == hi_idx) begin
            low_eff  = '0;
            high_eff = TOP_IDX;
        end else begin
            low_eff  = lo_idx;
            high_eff = hi_idx;
        end
        first_idx = reverse ? high_eff : low_eff;
        last_idx  = reverse ? low_eff  : high_eff;
    end
endmodule

// File: rtl/lps_dwell.sv
module lps_dwell #(
    parameter int IDX_W  = 4,
    parameter int DUR_W  = 9,
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic              tick,
    input  logic [IDX_W-1:0]  pos,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              pause_lo,
    input  logic              pause_hi,
    input  logic [DUR_W-1:0]  step_dur,
    input  logic [MULT_W-1:0] lo_mult,
    input  logic [MULT_W-1:0] hi_mult,
    output logic              step_done
);
    localparam int LEN_W = DUR_W + MULT_W;

    logic [LEN_W-1:0]  base_len, hold_len, cnt_q;
    logic [MULT_W-1:0] mult_sel;
    logic              stretched;

    always_comb begin
        base_len  = (step_dur == '0) ? LEN_W'(1) : LEN_W'(step_dur);
        stretched = 1'b1;
        if (pause_lo && (pos == first_idx)) begin
            mult_sel = lo_mult;
        end else if (pause_hi && (pos == last_idx)) begin
            mult_sel = hi_mult;
        end else begin
            mult_sel  = '0;
            stretched = 1'b0;
        end
        if (stretched && (mult_sel != '0)) begin
            hold_len = base_len * LEN_W'(mult_sel);
        end else begin
            hold_len = base_len;
        end
    end

    // Compare with >= so a hold shortened mid-way still ends.
    assign step_done = run && tick && ((cnt_q + LEN_W'(1)) >= hold_len);

    always_ff @(posedge clk) begin
        if (rst || restart || step_done) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/lut_pattern_seq.sv
module lut_pattern_seq #(
    parameter int DEPTH  = 16,
    parameter int DUTY_W = 9,
    parameter int DUR_W  = 9,
    parameter int MULT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lut_we,
    input  logic [IDX_W-1:0]  lut_waddr,
    input  logic [DUTY_W-1:0] lut_wdata,
    input  logic [IDX_W-1:0]  cfg_lo_idx,
    input  logic [IDX_W-1:0]  cfg_hi_idx,
    input  logic [DUR_W-1:0]  cfg_step_dur,
    input  logic [MULT_W-1:0] cfg_lo_mult,
    input  logic [MULT_W-1:0] cfg_hi_mult,
    input  logic              cfg_reverse,
    input  logic              cfg_oneshot,
    input  logic              cfg_pingpong,
    input  logic              cfg_pause_lo_en,
    input  logic              cfg_pause_hi_en,
    input  logic              start,
    input  logic              stop,
    input  logic              ms_tick,
    output logic [DUTY_W-1:0] duty_out,
    output logic              busy
);
    import lps_pkg::*;

    mode_t            mode;
    logic [IDX_W-1:0] pos_q, first_idx, last_idx, pos_out, pos_back;
    dir_e             dir_q;
    logic             busy_q, step_done, go;
    act_e             act;

    assign mode = '{reverse:  cfg_reverse,  oneshot:  cfg_oneshot,
                    pingpong: cfg_pingpong, pause_lo: cfg_pause_lo_en,
                    pause_hi: cfg_pause_hi_en};
    assign go = start && !stop;

    lps_lut #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DUTY_W(DUTY_W)) lut_i (
        .clk(clk), .rst(rst), .we(lut_we), .waddr(lut_waddr),
        .wdata(lut_wdata), .raddr(pos_q), .rdata(duty_out)
    );

    lps_window #(.DEPTH(DEPTH), .IDX_W(IDX_W)) win_i (
        .lo_idx(cfg_lo_idx), .hi_idx(cfg_hi_idx), .reverse(mode.reverse),
        .first_idx(first_idx), .last_idx(last_idx)
    );

    lps_dwell #(.IDX_W(IDX_W), .DUR_W(DUR_W), .MULT_W(MULT_W)) dwell_i (
        .clk(clk), .rst(rst), .restart(go || stop), .run(busy_q),
        .tick(ms_tick), .pos(pos_q), .first_idx(first_idx),
        .last_idx(last_idx), .pause_lo(mode.pause_lo),
        .pause_hi(mode.pause_hi), .step_dur(cfg_step_dur),
        .lo_mult(cfg_lo_mult), .hi_mult(cfg_hi_mult), .step_done(step_done)
    );

    // Neighbour indices in pattern order.
    assign pos_out  = mode.reverse ? pos_q - IDX_W'(1) : pos_q + IDX_W'(1);
    assign pos_back = mode.reverse ? pos_q + IDX_W'(1) : pos_q - IDX_W'(1);

    always_comb begin
        if (dir_q == DIR_OUT) begin
            if (pos_q != last_idx)   act = ACT_STEP_OUT;
            else if (mode.pingpong)  act = ACT_TURN;
            else if (mode.oneshot)   act = ACT_FINISH;
            else                     act = ACT_WRAP;
        end else begin
            if (pos_q != first_idx)  act = ACT_STEP_BACK;
            else if (mode.oneshot)   act = ACT_FINISH;
            else                     act = ACT_TURN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            dir_q  <= DIR_OUT;
            busy_q <= 1'b0;
        end else if (stop) begin
            busy_q <= 1'b0;
        end else if (go) begin
            pos_q  <= first_idx;
            dir_q  <= DIR_OUT;
            busy_q <= 1'b1;
        end else if (step_done) begin
            unique case (act)
                ACT_STEP_OUT:  pos_q <= pos_out;
                ACT_STEP_BACK: pos_q <= pos_back;
                ACT_WRAP:      pos_q <= first_idx;
                ACT_TURN: begin
                    if (dir_q == DIR_OUT) begin
                        pos_q <= pos_back;
                        dir_q <= DIR_BACK;
                    end else begin
                        pos_q <= pos_out;
                        dir_q <= DIR_OUT;
                    end
                end
                ACT_FINISH:    busy_q <= 1'b0;
                default:       busy_q <= 1'b0;
            endcase
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/lps_chk.sv
module lps_chk #(
    parameter int IDX_W  = 4,
    parameter int DUTY_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              stop,
    input logic              ms_tick,
    input logic              busy,
    input logic [IDX_W-1:0]  pos,
    input logic              lut_we,
    input logic [IDX_W-1:0]  lut_waddr,
    input logic [DUTY_W-1:0] lut_wdata,
    input logic [DUTY_W-1:0] duty_out
);
    // R1: idle right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !busy);

    // R10: stop clears busy, even with start
    a_r10_stop_clears_busy: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);

    // R3: start raises busy
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> busy);

    // R5: no tick, no movement
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!ms_tick && !start) |=> $stable(pos));

    // R2: write to the current entry shows on the output
    a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
        (lut_we && (lut_waddr == pos) && !ms_tick && !start)
        |=> (duty_out == $past(lut_wdata)));
endmodule

bind lut_pattern_seq lps_chk #(.IDX_W(IDX_W), .DUTY_W(DUTY_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .ms_tick(ms_tick),
    .busy(busy), .pos(pos_q), .lut_we(lut_we), .lut_waddr(lut_waddr),
    .lut_wdata(lut_wdata), .duty_out(duty_out)
);

// File: tb/lut_pattern_seq_tb_top.sv
module lut_pattern_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lut_we = 1'b0;
    logic [3:0] lut_waddr = '0;
    logic [8:0] lut_wdata = '0;
    logic [3:0] cfg_lo_idx = '0, cfg_hi_idx = '0;
    logic [8:0] cfg_step_dur = 9'd1;
    logic [7:0] cfg_lo_mult = 8'd3, cfg_hi_mult = 8'd2;
    logic       cfg_reverse = 0, cfg_oneshot = 0, cfg_pingpong = 0;
    logic       cfg_pause_lo_en = 0, cfg_pause_hi_en = 0;
    logic       start = 0, stop = 0, ms_tick = 0;
    logic [8:0] duty_out;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lut_pattern_seq dut_i (
        .clk(clk), .rst(rst), .lut_we(lut_we), .lut_waddr(lut_waddr),
        .lut_wdata(lut_wdata), .cfg_lo_idx(cfg_lo_idx), .cfg_hi_idx(cfg_hi_idx),
        .cfg_step_dur(cfg_step_dur), .cfg_lo_mult(cfg_lo_mult),
        .cfg_hi_mult(cfg_hi_mult), .cfg_reverse(cfg_reverse),
        .cfg_oneshot(cfg_oneshot), .cfg_pingpong(cfg_pingpong),
        .cfg_pause_lo_en(cfg_pause_lo_en), .cfg_pause_hi_en(cfg_pause_hi_en),
        .start(start), .stop(stop), .ms_tick(ms_tick),
        .duty_out(duty_out), .busy(busy)
    );

    // {lo, hi, 1'b0, pingpong, oneshot, reverse, busy[7:0], index seq[31:0]}
    // Pace one tick per step, pauses off (multipliers non-zero: R6 ignore).
    localparam logic [51:0] VEC [8] = '{
        {4'd2, 4'd5, 4'b0000, 8'hFF, 32'h23452345},  // R4 forward wrap
        {4'd2, 4'd5, 4'b0001, 8'hFF, 32'h54325432},  // R4 reverse wrap
        {4'd2, 4'd5, 4'b0100, 8'hFF, 32'h23454323},  // R7 ping-pong
        {4'd2, 4'd5, 4'b0101, 8'hFF, 32'h54323454},  // R7 reverse ping-pong
        {4'd2, 4'd4, 4'b0010, 8'hE0, 32'h23444444},  // R8 one-shot
        {4'd3, 4'd3, 4'b0000, 8'hFF, 32'h01234567},  // R9 whole table
        {4'd5, 4'd5, 4'b0001, 8'hFF, 32'hFEDCBA98},  // R9 whole table reverse
        {4'd1, 4'd3, 4'b0110, 8'hF8, 32'h12321111}   // R8 one-shot ping-pong
    };

    function automatic int entry_val(input int idx);
        return 10 * idx + 3;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic write_lut(input int a, input int d);
        lut_we = 1'b1; lut_waddr = 4'(a); lut_wdata = 9'(d);
        @(negedge clk);
        lut_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 duty", int'(duty_out), 0);

        for (int i = 0; i < 16; i++) write_lut(i, entry_val(i));
        check("R2 entry0 write", int'(duty_out), entry_val(0));

        // Table walk
        for (int v = 0; v < 8; v++) begin
            cfg_lo_idx   = VEC[v][51:48];
            cfg_hi_idx   = VEC[v][47:44];
            cfg_pingpong = VEC[v][42];
            cfg_oneshot  = VEC[v][41];
            cfg_reverse  = VEC[v][40];
            cfg_step_dur = 9'd1;
            pulse_start();
            for (int s = 0; s < 8; s++) begin
                if (s > 0) tick();
                check($sformatf("R3/R4/R7/R8/R9 vec%0d step%0d duty", v, s),
                      int'(duty_out), entry_val(int'(VEC[v][31 - 4*s -: 4])));
                check($sformatf("R3/R8 vec%0d step%0d busy", v, s),
                      int'(busy), int'(VEC[v][39 - s]));
            end
        end

        // R5: three-tick hold, ticks while idle ignored
        cfg_lo_idx = 4'd2; cfg_hi_idx = 4'd5;
        cfg_reverse = 0; cfg_oneshot = 0; cfg_pingpong = 0;
        cfg_step_dur = 9'd3;
        pulse_start();
        tick(); tick();
        check("R5 hold before end", int'(duty_out), entry_val(2));
        tick();
        check("R5 step on third tick", int'(duty_out), entry_val(3));
        cfg_step_dur = 9'd0;
        tick();
        check("R5 zero duration counts as one", int'(duty_out), entry_val(4));

        // R10: stop holds output; ticks ignored; stop beats start
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R10 busy cleared", int'(busy), 0);
        tick(); tick();
        check("R10 duty held", int'(duty_out), entry_val(4));
        check("R5 idle tick ignored", int'(duty_out), entry_val(4));
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check("R10 stop wins over start", int'(busy), 0);

        // R2: writes to the shown entry and to another entry
        write_lut(4, 77);
        check("R2 current entry rewrite", int'(duty_out), 77);
        write_lut(9, 200);
        check("R2 other entry no effect", int'(duty_out), 77);
        write_lut(4, entry_val(4));
        write_lut(9, entry_val(9));

        // R6: stretched ends, dur=2, lo mult 3 -> 6 ticks, hi mult 2 -> 4 ticks
        cfg_lo_idx = 4'd2; cfg_hi_idx = 4'd3;
        cfg_step_dur = 9'd2;
        cfg_pause_lo_en = 1; cfg_pause_hi_en = 1;
        pulse_start();
        for (int t = 0; t < 5; t++) tick();
        check("R6 low pause still held", int'(duty_out), entry_val(2));
        tick();
        check("R6 low pause ends on tick 6", int'(duty_out), entry_val(3));
        for (int t = 0; t < 3; t++) tick();
        check("R6 high pause still held", int'(duty_out), entry_val(3));
        tick();
        check("R6 high pause ends on tick 4", int'(duty_out), entry_val(2));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule